// File: doc/BRIEF.md
# Transport Stream Packet FIFO Writer

This block sits between a transport stream capture front end and a 64-bit receive FIFO. Packet bytes arrive one per clock on an 8-bit bus. The capture logic feeds it the upper eight bits of its 10-bit video input. A packet-start strobe marks the first byte of each 188-byte packet. The writer packs eight bytes into each FIFO word, in little-endian or big-endian lane order. The order is chosen by a configuration input, which is sampled on each packet-start byte. The 188th byte closes a final word that holds only four bytes; the unused lanes are padded with zeros.

When a packet ends, the writer pulses a request to the timestamp synchronizer and waits for the sample to come back. It then writes one status word behind the packet. That word holds the 42-bit clock-reference sample (a 33-bit base and a 9-bit extension) and two error flags. Data words and status words leave through a single registered write port. A full FIFO suppresses writes, and any packet that loses data to a full FIFO is flagged as errored.

Top module: `ts_pkt_writer`

## Requirements
- R1: After reset, `fifo_we` and `ts_req` are low. Bytes that arrive while idle without `cap_sop` produce no write.
- R2: In little-endian order, byte k (0..7) of each group of eight goes to bits 8k+7:8k of the word.
- R3: In big-endian order, byte k of each group goes to bits 63-8k:56-8k. A 188-byte packet gives 23 full words and a 24th word holding bytes 184..187, whose unused lanes are zero.
- R4: The lane order is sampled from `cfg_big_endian` on the packet-start byte. Changes to that input later in the packet do not affect that packet.
- R5: `ts_req` is high for exactly one cycle: the cycle after the last (188th) byte is accepted.
- R6: While waiting for a timestamp, the status word is written in the cycle after the first cycle in which `ts_vld` is high and `fifo_full` is low. In little-endian order the word is {packet error at 63, start error at 62, zeros 61:42, `ts_value` 41:0}. In big-endian order it is the byte-reversed form of that value.
- R7: A data word is written in the cycle after the byte that completes it. Idle cycles between bytes are allowed and do not disturb the packing.
- R8: A byte that arrives while `fifo_full` is high is stored as zero and sets the packet error flag. A word whose completing byte arrives while full is not written. The status word is held back while `fifo_full` is high.
- R9: `cap_err` high on an accepted byte sets the packet error flag of that packet.
- R10: A `cap_sop` on a byte in the middle of a packet sets the start error flag. It also discards the partly filled word and makes that byte byte 0 of a new 188-byte count.
- R11: Bytes and start strobes that arrive while a timestamp is awaited are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_byte | input | 8 | Captured stream byte |
| cap_vld | input | 1 | `cap_byte` holds a byte this cycle |
| cap_sop | input | 1 | This byte starts a packet |
| cap_err | input | 1 | Upstream error seen on this byte |
| cfg_big_endian | input | 1 | 1 selects big-endian lane order |
| ts_value | input | 42 | Timestamp sample: extension 41:33, base 32:0 |
| ts_vld | input | 1 | `ts_value` is valid |
| fifo_full | input | 1 | FIFO cannot take a write |
| ts_req | output | 1 | One-cycle timestamp request |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | 64 | FIFO write data |

## Verification
The hardest situations are the ones that combine the full input with packet framing. A full FIFO during the byte that completes a word must remove exactly that word. A full FIFO during the 188th byte must drop the padded word and still raise the timestamp request. The stimulus raises `fifo_full` for a single chosen byte index, and also holds it high across a pending timestamp. Each expected word is built from the byte index, so one misplaced lane or one extra write breaks the scoreboard order. The tests also place a second start strobe at byte 13 and send stray start bytes while a timestamp is awaited.

// File: rtl/ts_pkt_pkg.sv
package ts_pkt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_WAIT    = 2'd2
  } wr_state_e;
endpackage

// File: rtl/ts_pkt_ctrl.sv
module ts_pkt_ctrl
  import ts_pkt_pkg::*;
#(
  parameter int PKT_LEN    = 188,
  parameter int WORD_BYTES = 8,
  localparam int CNT_W  = $clog2(PKT_LEN),
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_vld,
  input  logic              cap_sop,
  input  logic              cap_err,
  input  logic              cfg_big,
  input  logic              fifo_full,
  input  logic              ts_vld,
  output logic              accept,
  output logic              start,
  output logic              word_done,
  output logic              word_keep,
  output logic [LANE_W-1:0] lane,
  output logic              be_cur,
  output logic              perr_q,
  output logic              serr_q,
  output logic              st_fire,
  output logic              ts_req
);
  wr_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             be_q;
  logic             restart;
  logic             last;

  always_comb begin
    start     = cap_vld && cap_sop && (state_q != ST_WAIT);
    restart   = cap_vld && cap_sop && (state_q == ST_COLLECT);
    accept    = cap_vld && ((state_q == ST_COLLECT) || (state_q == ST_IDLE && cap_sop));
    pos       = start ? '0 : cnt_q;
    lane      = pos[LANE_W-1:0];
    last      = accept && (pos == CNT_W'(PKT_LEN - 1));
    word_done = accept && ((&lane) || last);
    word_keep = word_done && !fifo_full;
    be_cur    = start ? cfg_big : be_q;
    st_fire   = (state_q == ST_WAIT) && ts_vld && !fifo_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      be_q    <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      ts_req  <= 1'b0;
    end else begin
      ts_req <= last;
      if (start) be_q <= cfg_big;
      if (accept) begin
        cnt_q   <= last ? '0 : pos + 1'b1;
        state_q <= last ? ST_WAIT : ST_COLLECT;
        if (state_q == ST_IDLE) begin
          perr_q <= fifo_full || cap_err;
          serr_q <= 1'b0;
        end else begin
          perr_q <= perr_q || fifo_full || cap_err;
          serr_q <= serr_q || restart;
        end
      end else if (st_fire) begin
        state_q <= ST_IDLE;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(PKT_LEN)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    ts_req |=> !ts_req); // R5
  AST_REQ_WAITS: assert property (@(posedge clk) disable iff (rst)
    ts_req |-> (state_q == ST_WAIT)); // R5
endmodule

// File: rtl/ts_lane_packer.sv
module ts_lane_packer #(
  parameter int WORD_BYTES = 8,
  parameter int BYTE_W     = 8,
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int WORD_W = WORD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              clear,
  input  logic              word_done,
  input  logic              drop,
  input  logic              big,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] merged
);
  logic [WORD_W-1:0] lanes_q;
  logic [LANE_W-1:0] slot;

  always_comb begin
    slot   = big ? (LANE_W'(WORD_BYTES - 1) - lane) : lane;
    merged = clear ? '0 : lanes_q;
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (LANE_W'(k) == slot) merged[k*BYTE_W +: BYTE_W] = drop ? '0 : byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lanes_q <= '0;
    else if (accept) lanes_q <= word_done ? '0 : merged;
  end
endmodule

// File: rtl/ts_out_reg.sv
module ts_out_reg #(
  parameter int WORD_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int TS_W       = 42,
  localparam int WORD_W = WORD_BYTES * BYTE_W,
  localparam int RSV_W  = WORD_W - 2 - TS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_keep,
  input  logic [WORD_W-1:0] data_word,
  input  logic              st_fire,
  input  logic              perr,
  input  logic              serr,
  input  logic              big,
  input  logic              fifo_full,
  input  logic [TS_W-1:0]   ts_in,
  output logic              fifo_we,
  output logic [WORD_W-1:0] fifo_wdata
);
  logic [WORD_W-1:0] status;
  logic [WORD_W-1:0] swapped;

  assign status = {perr, serr, {RSV_W{1'b0}}, ts_in};

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_rev
    assign swapped[k*BYTE_W +: BYTE_W] = status[(WORD_BYTES-1-k)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_we <= data_keep || st_fire;
      if (data_keep)    fifo_wdata <= data_word;
      else if (st_fire) fifo_wdata <= big ? swapped : status;
    end
  end

  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> $past(!fifo_full)); // R8
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(data_keep && st_fire)); // R6
endmodule

// File: rtl/ts_pkt_writer.sv
module ts_pkt_writer #(
  parameter int PKT_LEN    = 188,
  parameter int WORD_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int TS_W       = 42,
  localparam int LANE_W = $clog2(WORD_BYTES),
  localparam int WORD_W = WORD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              cap_vld,
  input  logic              cap_sop,
  input  logic              cap_err,
  input  logic              cfg_big_endian,
  input  logic [TS_W-1:0]   ts_value,
  input  logic              ts_vld,
  input  logic              fifo_full,
  output logic              ts_req,
  output logic              fifo_we,
  output logic [WORD_W-1:0] fifo_wdata
);
  logic              accept, start, word_done, word_keep, be_cur;
  logic              perr, serr, st_fire;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] merged;

  ts_pkt_ctrl #(.PKT_LEN(PKT_LEN), .WORD_BYTES(WORD_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_sop(cap_sop), .cap_err(cap_err),
    .cfg_big(cfg_big_endian), .fifo_full(fifo_full), .ts_vld(ts_vld),
    .accept(accept), .start(start), .word_done(word_done), .word_keep(word_keep),
    .lane(lane), .be_cur(be_cur), .perr_q(perr), .serr_q(serr),
    .st_fire(st_fire), .ts_req(ts_req)
  );

  ts_lane_packer #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .accept(accept), .clear(start), .word_done(word_done),
    .drop(fifo_full), .big(be_cur), .lane(lane), .byte_in(cap_byte), .merged(merged)
  );

  ts_out_reg #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W), .TS_W(TS_W)) u_out (
    .clk(clk), .rst(rst), .data_keep(word_keep), .data_word(merged),
    .st_fire(st_fire), .perr(perr), .serr(serr), .big(be_cur),
    .fifo_full(fifo_full), .ts_in(ts_value), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata)
  );

  AST_REQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    ts_req |-> $past(cap_vld)); // R5
endmodule

// File: tb/ts_pkt_writer_test.sv
module ts_pkt_writer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cap_byte = '0;
  logic        cap_vld = 1'b0, cap_sop = 1'b0, cap_err = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic [41:0] ts_value = '0;
  logic        ts_vld = 1'b0, fifo_full = 1'b0;
  logic        ts_req, fifo_we;
  logic [63:0] fifo_wdata;

  int total = 0, bad = 0, wr_cnt = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  ts_pkt_writer uut (
    .clk(clk), .rst(rst), .cap_byte(cap_byte), .cap_vld(cap_vld), .cap_sop(cap_sop),
    .cap_err(cap_err), .cfg_big_endian(cfg_big_endian), .ts_value(ts_value),
    .ts_vld(ts_vld), .fifo_full(fifo_full), .ts_req(ts_req), .fifo_we(fifo_we),
    .fifo_wdata(fifo_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rev8(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[k*8 +: 8] = v[(7-k)*8 +: 8];
    return r;
  endfunction

  // monitor: pop expected words as the design writes
  always @(negedge clk) begin
    if (!rst && fifo_we) begin
      wr_cnt++;
      if (exp_q.size() == 0) chk(0, "R1/R11 unexpected write", fifo_wdata, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(fifo_wdata == e, t, fifo_wdata, e);
      end
    end
  end

  task automatic push(input logic [63:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic run_pkt(input bit be, input int seed, input int full_at, input int err_at,
                         input int restart_at, input bit flip, input bit gaps, input bit stray,
                         input bit ts_block, input logic [41:0] ts, input string t);
    logic [63:0] w;
    int p, nsend, ln, slot;
    bit perr, serr, drop, sop;
    logic [7:0] b;
    w = '0; p = 0; perr = 0; serr = 0;
    nsend = (restart_at > 0) ? restart_at + 188 : 188;
    for (int i = 0; i < nsend; i++) begin
      sop = (i == 0) || (restart_at > 0 && i == restart_at);
      if (restart_at > 0 && i == restart_at) begin serr = 1; p = 0; w = '0; end
      b = 8'(seed + i * 7);
      drop = (i == full_at);
      if (gaps && (i % 5 == 4)) begin
        @(negedge clk);
        cap_vld = 0; cap_sop = 0; cap_err = 0; fifo_full = 0;
      end
      @(negedge clk);
      cap_vld = 1; cap_byte = b; cap_sop = sop; cap_err = (i == err_at); fifo_full = drop;
      cfg_big_endian = (flip && i >= 1) ? ~be : be;
      ln = p % 8;
      slot = be ? 7 - ln : ln;
      if (!drop) w[slot*8 +: 8] = b;
      perr = perr | drop | (i == err_at);
      if (ln == 7 || p == 187) begin
        if (!drop) push(w, t);
        w = '0;
      end
      p++;
    end
    @(negedge clk);
    cap_vld = 0; cap_sop = 0; cap_err = 0; fifo_full = 0; cfg_big_endian = be;
    chk(ts_req == 1'b1, "R5 request high after last byte", 64'(ts_req), 64'd1);
    if (stray) begin cap_vld = 1; cap_sop = 1; cap_byte = 8'hAA; end
    @(negedge clk);
    chk(ts_req == 1'b0, "R5 request lasts one cycle", 64'(ts_req), 64'd0);
    if (stray) begin
      cap_sop = 0;
      repeat (3) @(negedge clk);
      cap_sop = 1;
      @(negedge clk);
      cap_vld = 0; cap_sop = 0;
    end
    begin
      logic [63:0] s;
      s = {perr, serr, 20'b0, ts};
      push(be ? rev8(s) : s, {t, " status"});
    end
    ts_value = ts; ts_vld = 1;
    if (ts_block) begin
      fifo_full = 1;
      repeat (2) @(negedge clk);
      fifo_full = 0;
    end
    @(negedge clk);
    ts_vld = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(fifo_we == 1'b0, "R1 we low after reset", 64'(fifo_we), 64'd0);
    chk(ts_req == 1'b0, "R1 req low after reset", 64'(ts_req), 64'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cap_vld = 1; cap_byte = 8'(i); cap_sop = 0;
    end
    @(negedge clk);
    cap_vld = 0;
    repeat (2) @(negedge clk);
    chk(wr_cnt == 0, "R1 idle bytes ignored", 64'(wr_cnt), 64'd0);

    run_pkt(0, 3,  -1, -1, 0,  0, 0, 0, 0, 42'h2AB_CDEF_0123, "R2 R3 R6 R7 little");
    run_pkt(1, 11, -1, -1, 0,  0, 0, 0, 0, 42'h155_1234_5678, "R3 R6 big");
    run_pkt(0, 20, -1, -1, 0,  1, 0, 0, 0, 42'h001_0000_0001, "R4 endian latched");
    run_pkt(1, 40, -1, 50, 0,  0, 1, 0, 0, 42'h3FF_FFFF_FFFF, "R7 R9 gaps and error");
    run_pkt(0, 5,  15, -1, 0,  0, 0, 0, 0, 42'h0AA_5555_AAAA, "R8 completing byte full");
    run_pkt(1, 9,  20, -1, 0,  0, 0, 0, 1, 42'h123_4567_89AB, "R8 mid byte full and held status");
    run_pkt(0, 77, -1, -1, 13, 0, 0, 0, 0, 42'h0F0_F0F0_F0F0, "R10 restart");
    run_pkt(1, 99, -1, -1, 0,  0, 0, 1, 0, 42'h200_0000_0000, "R11 stray bytes in wait");
    run_pkt(0, 1,  187, -1, 0, 0, 0, 0, 0, 42'h000_0000_BEEF, "R8 last byte full");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected words written", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule